// File: doc/BRIEF.md
# Channel Group Teardown Sequencer

This block removes one faulted or stuck channel group from a runlist without software stepping through each action. After a start pulse it turns scheduling off for the runlist, disables the target group's channels, and fires a preempt request. It then waits for the serving PBDMAs to drain, servicing their interrupts through a request/acknowledge handshake. Next it judges every engine from its context status and IDs, resets the engines that still hold the group, and turns scheduling back on.

Each engine is judged on its own. Depending on its context status, the block compares either the current ID or the next ID with the target group. A status that never settles is capped by a poll limit, which forces a reset. In the immediate mode, the drain and the judging are skipped and every engine is reset.

Top module: `gts_teardown_seq`

## Requirements
- R1: While `rst` is high every output is low. A `start_i` pulse seen while idle raises `sched_disable_o` for exactly one cycle, in the cycle after the pulse.
- R2: `chan_disable_o` pulses for one cycle in the cycle right after `sched_disable_o`.
- R3: `preempt_o` pulses for one cycle in the cycle right after `chan_disable_o`. No completion of the preempt is awaited.
- R4: After the preempt, the block waits until every serving PBDMA has `pbdma_chan_active_i` low. While it waits, a pending `pbdma_intr_i` raises `intr_svc_req_o`, which is held until `intr_svc_ack_i`. No engine step and no scheduling enable happens before the drain ends.
- R5: Context status SWITCH (code 4, and the unused codes 5 to 7) keeps the engine polling. A later INVALID then ends the poll with no reset.
- R6: Context status INVALID (code 0) marks the engine as needing no reset.
- R7: For context status VALID (code 1) or SAVE (code 2), the engine is marked for reset exactly when its current ID equals the target.
- R8: For context status LOAD (code 3), the engine is marked for reset exactly when its next ID equals the target, whatever its current ID is.
- R9: Marked engines get `eng_halt_o` for one cycle, then `eng_reset_o` for one cycle with halt still high, then halt alone until all marked engines acknowledge re-initialisation. Unmarked engines see neither strobe.
- R10: `sched_enable_o` pulses for one cycle after the engine phase. `done_o` follows in the next cycle and lasts one cycle.
- R11: An engine still unresolved after `POLL_LIMIT` poll cycles is marked for reset.
- R12: When `imm_reset_i` is high with the start pulse, the PBDMA drain and the status judging are skipped and every engine is marked for reset.
- R13: A `start_i` pulse while a teardown is running is ignored: it adds no strobe and no extra `done_o`.
- R14: `eng_reset_need_o` is cleared at start and holds the verdicts from judging until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| imm_reset_i | input | 1 | Immediate mode, sampled with start |
| target_id_i | input | ID_W | Group to tear down, sampled with start |
| pbdma_chan_active_i | input | NUM_PBDMA | Channel status not INVALID, per PBDMA |
| pbdma_intr_i | input | NUM_PBDMA | Pending PBDMA interrupt |
| intr_svc_ack_i | input | 1 | Interrupt service finished |
| eng_ctx_stat_i | input | 3*NUM_ENG | Context status per engine |
| eng_cur_id_i | input | ID_W*NUM_ENG | Current group ID per engine |
| eng_next_id_i | input | ID_W*NUM_ENG | Next group ID per engine |
| eng_reinit_ack_i | input | NUM_ENG | Re-initialisation done per engine |
| sched_disable_o | output | 1 | Scheduling-off strobe |
| chan_disable_o | output | 1 | Group channel-disable strobe |
| preempt_o | output | 1 | Runlist preempt strobe |
| intr_svc_req_o | output | 1 | Interrupt service request |
| eng_halt_o | output | NUM_ENG | Memory-interface halt per engine |
| eng_reset_o | output | NUM_ENG | Reset per engine |
| eng_reset_need_o | output | NUM_ENG | Engine judged to need reset |
| sched_enable_o | output | 1 | Scheduling-on strobe |
| done_o | output | 1 | Teardown finished pulse |

## Verification
Engine status patterns are chosen so that each comparison rule gets a case of its own. In the LOAD case, the two engines carry the target in opposite ID fields, so a design that compares the wrong field inverts the reset mask. A SWITCH that later resolves to INVALID is set against a SWITCH that never resolves: the first must end with no reset and the second with a forced reset, which tells polling apart from timing out. A PBDMA that is busy with a pending interrupt proves that the handshake runs before anything downstream. Immediate mode is run with the PBDMAs held busy and every status INVALID, which shows that both waits are bypassed. A second start in mid-run must leave the stream of strobes unchanged.

// File: rtl/gts_pkg.sv
package gts_pkg;

    // Engine context status codes seen on eng_ctx_stat_i
    typedef enum logic [2:0] {
        CTX_INVALID = 3'd0,
        CTX_VALID   = 3'd1,
        CTX_SAVE    = 3'd2,
        CTX_LOAD    = 3'd3,
        CTX_SWITCH  = 3'd4
    } ctx_stat_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCHED_OFF,
        ST_CHAN_OFF,
        ST_PREEMPT,
        ST_PBDMA_WAIT,
        ST_INTR_SVC,
        ST_ENG_JUDGE,
        ST_RST_HALT,
        ST_RST_ON,
        ST_RST_WAIT,
        ST_SCHED_ON,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic resolved;
        logic need;
    } verdict_t;

    // Verdict for one poll sample; unresolved codes keep the poll going
    function automatic verdict_t judge_ctx(logic [2:0] st, logic cur_hit, logic next_hit);
        verdict_t v;
        v = '0;
        unique case (st)
            CTX_INVALID: begin v.resolved = 1'b1; v.need = 1'b0;     end
            CTX_VALID,
            CTX_SAVE:    begin v.resolved = 1'b1; v.need = cur_hit;  end
            CTX_LOAD:    begin v.resolved = 1'b1; v.need = next_hit; end
            default:     begin v.resolved = 1'b0; v.need = 1'b0;     end
        endcase
        return v;
    endfunction

endpackage

// File: rtl/gts_pbdma_drain.sv
module gts_pbdma_drain #(
    parameter int NUM_PBDMA = 2,
    parameter logic [NUM_PBDMA-1:0] SERVE_MASK = '1
) (
    input  logic [NUM_PBDMA-1:0] chan_active_i,
    input  logic [NUM_PBDMA-1:0] intr_i,
    output logic                 all_idle_o,
    output logic                 intr_pend_o
);
    logic [NUM_PBDMA-1:0] busy_q;
    logic [NUM_PBDMA-1:0] intr_q;

    // Only PBDMAs that serve this runlist take part in the drain
    for (genvar p = 0; p < NUM_PBDMA; p++) begin : g_pb
        if (SERVE_MASK[p]) begin : g_on
            assign busy_q[p] = chan_active_i[p];
            assign intr_q[p] = intr_i[p];
        end else begin : g_off
            assign busy_q[p] = 1'b0;
            assign intr_q[p] = 1'b0;
        end
    end

    assign all_idle_o  = ~|busy_q;
    assign intr_pend_o = |intr_q;
endmodule

// File: rtl/gts_eng_judge.sv
module gts_eng_judge
    import gts_pkg::*;
#(
    parameter int ID_W       = 8,
    parameter int POLL_LIMIT = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear_i,
    input  logic            poll_i,
    input  logic            force_i,
    input  logic [2:0]      stat_i,
    input  logic [ID_W-1:0] cur_id_i,
    input  logic [ID_W-1:0] next_id_i,
    input  logic [ID_W-1:0] target_i,
    output logic            resolved_o,
    output logic            need_o
);
    localparam int CW = $clog2(POLL_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(POLL_LIMIT - 1);

    logic [CW-1:0] wait_cnt;
    verdict_t      sample;

    assign sample = judge_ctx(stat_i, cur_id_i == target_i, next_id_i == target_i);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            resolved_o <= 1'b0;
            need_o     <= 1'b0;
            wait_cnt   <= '0;
        end else if (poll_i && !resolved_o) begin
            if (force_i) begin
                resolved_o <= 1'b1;
                need_o     <= 1'b1;
            end else if (sample.resolved) begin
                resolved_o <= 1'b1;
                need_o     <= sample.need;
            end else if (wait_cnt == LAST) begin
                // status never settled: assume the group is stuck on it
                resolved_o <= 1'b1;
                need_o     <= 1'b1;
            end else begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/gts_teardown_seq.sv
module gts_teardown_seq
    import gts_pkg::*;
#(
    parameter int NUM_PBDMA  = 2,
    parameter int NUM_ENG    = 2,
    parameter int ID_W       = 8,
    parameter int POLL_LIMIT = 16,
    parameter logic [NUM_PBDMA-1:0] PBDMA_SERVE_MASK = '1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    imm_reset_i,
    input  logic [ID_W-1:0]         target_id_i,
    input  logic [NUM_PBDMA-1:0]    pbdma_chan_active_i,
    input  logic [NUM_PBDMA-1:0]    pbdma_intr_i,
    input  logic                    intr_svc_ack_i,
    input  logic [3*NUM_ENG-1:0]    eng_ctx_stat_i,
    input  logic [ID_W*NUM_ENG-1:0] eng_cur_id_i,
    input  logic [ID_W*NUM_ENG-1:0] eng_next_id_i,
    input  logic [NUM_ENG-1:0]      eng_reinit_ack_i,
    output logic                    sched_disable_o,
    output logic                    chan_disable_o,
    output logic                    preempt_o,
    output logic                    intr_svc_req_o,
    output logic [NUM_ENG-1:0]      eng_halt_o,
    output logic [NUM_ENG-1:0]      eng_reset_o,
    output logic [NUM_ENG-1:0]      eng_reset_need_o,
    output logic                    sched_enable_o,
    output logic                    done_o
);
    seq_state_e state_q, state_d;
    logic [ID_W-1:0] tgt_q;
    logic            imm_q;
    logic            kick;
    logic            drained, intr_pend;
    logic [NUM_ENG-1:0] eng_resolved, eng_need;

    assign kick = (state_q == ST_IDLE) && start_i;

    gts_pbdma_drain #(
        .NUM_PBDMA  (NUM_PBDMA),
        .SERVE_MASK (PBDMA_SERVE_MASK)
    ) u_drain (
        .chan_active_i (pbdma_chan_active_i),
        .intr_i        (pbdma_intr_i),
        .all_idle_o    (drained),
        .intr_pend_o   (intr_pend)
    );

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        gts_eng_judge #(
            .ID_W       (ID_W),
            .POLL_LIMIT (POLL_LIMIT)
        ) u_judge (
            .clk        (clk),
            .rst        (rst),
            .clear_i    (kick),
            .poll_i     (state_q == ST_ENG_JUDGE),
            .force_i    (imm_q),
            .stat_i     (eng_ctx_stat_i[3*e +: 3]),
            .cur_id_i   (eng_cur_id_i[ID_W*e +: ID_W]),
            .next_id_i  (eng_next_id_i[ID_W*e +: ID_W]),
            .target_i   (tgt_q),
            .resolved_o (eng_resolved[e]),
            .need_o     (eng_need[e])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
            imm_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (kick) begin
                tgt_q <= target_id_i;
                imm_q <= imm_reset_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) state_d = ST_SCHED_OFF;
            ST_SCHED_OFF:  state_d = ST_CHAN_OFF;
            ST_CHAN_OFF:   state_d = ST_PREEMPT;
            ST_PREEMPT:    state_d = imm_q ? ST_ENG_JUDGE : ST_PBDMA_WAIT;
            ST_PBDMA_WAIT: begin
                if (intr_pend)    state_d = ST_INTR_SVC;
                else if (drained) state_d = ST_ENG_JUDGE;
            end
            ST_INTR_SVC:   if (intr_svc_ack_i) state_d = ST_PBDMA_WAIT;
            ST_ENG_JUDGE:  begin
                if (&eng_resolved)
                    state_d = (|eng_need) ? ST_RST_HALT : ST_SCHED_ON;
            end
            ST_RST_HALT:   state_d = ST_RST_ON;
            ST_RST_ON:     state_d = ST_RST_WAIT;
            ST_RST_WAIT:   begin
                if ((eng_reinit_ack_i & eng_need) == eng_need) state_d = ST_SCHED_ON;
            end
            ST_SCHED_ON:   state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    logic in_reset_phase;
    assign in_reset_phase = (state_q == ST_RST_HALT) || (state_q == ST_RST_ON) ||
                            (state_q == ST_RST_WAIT);

    assign sched_disable_o  = (state_q == ST_SCHED_OFF);
    assign chan_disable_o   = (state_q == ST_CHAN_OFF);
    assign preempt_o        = (state_q == ST_PREEMPT);
    assign intr_svc_req_o   = (state_q == ST_INTR_SVC);
    assign eng_halt_o       = in_reset_phase ? eng_need : '0;
    assign eng_reset_o      = (state_q == ST_RST_ON) ? eng_need : '0;
    assign eng_reset_need_o = eng_need;
    assign sched_enable_o   = (state_q == ST_SCHED_ON);
    assign done_o           = (state_q == ST_DONE);
endmodule

// File: rtl/gts_teardown_chk.sv
module gts_teardown_chk
    import gts_pkg::*;
#(
    parameter int NUM_PBDMA = 2,
    parameter int NUM_ENG   = 2,
    parameter logic [NUM_PBDMA-1:0] SERVE = '1
) (
    input logic                 clk,
    input logic                 rst,
    input seq_state_e           state_i,
    input logic [NUM_PBDMA-1:0] pbdma_intr_i,
    input logic                 sched_disable_o,
    input logic                 chan_disable_o,
    input logic                 preempt_o,
    input logic                 intr_svc_req_o,
    input logic [NUM_ENG-1:0]   eng_halt_o,
    input logic [NUM_ENG-1:0]   eng_reset_o,
    input logic [NUM_ENG-1:0]   eng_reset_need_o,
    input logic                 sched_enable_o,
    input logic                 done_o
);
    a_r2_chan_after_sched: assert property (@(posedge clk) disable iff (rst)
        sched_disable_o |=> chan_disable_o);

    a_r3_preempt_after_chan: assert property (@(posedge clk) disable iff (rst)
        chan_disable_o |=> preempt_o);

    a_r4_intr_serviced: assert property (@(posedge clk) disable iff (rst)
        (state_i == ST_PBDMA_WAIT && |(pbdma_intr_i & SERVE)) |=> intr_svc_req_o);

    a_r9_reset_under_halt: assert property (@(posedge clk) disable iff (rst)
        (|eng_reset_o) |-> (($past(eng_halt_o) & eng_reset_o) == eng_reset_o));

    a_r9_reset_only_marked: assert property (@(posedge clk) disable iff (rst)
        (eng_reset_o & ~eng_reset_need_o) == '0);

    a_r10_done_after_enable: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(sched_enable_o));

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sched_disable_o, chan_disable_o, preempt_o, sched_enable_o, done_o}));

    a_r13_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state_i != ST_IDLE) |=> !sched_disable_o);
endmodule

bind gts_teardown_seq gts_teardown_chk #(
    .NUM_PBDMA (NUM_PBDMA),
    .NUM_ENG   (NUM_ENG),
    .SERVE     (PBDMA_SERVE_MASK)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .state_i          (state_q),
    .pbdma_intr_i     (pbdma_intr_i),
    .sched_disable_o  (sched_disable_o),
    .chan_disable_o   (chan_disable_o),
    .preempt_o        (preempt_o),
    .intr_svc_req_o   (intr_svc_req_o),
    .eng_halt_o       (eng_halt_o),
    .eng_reset_o      (eng_reset_o),
    .eng_reset_need_o (eng_reset_need_o),
    .sched_enable_o   (sched_enable_o),
    .done_o           (done_o)
);

// File: tb/sim_gts_teardown_seq.sv
module sim_gts_teardown_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;
    localparam int NE = 2;
    localparam int IW = 8;
    localparam int PL = 16;
    localparam logic [IW-1:0] TGT = 8'h15;
    localparam logic [IW-1:0] OTH = 8'h22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic imm_reset_i = 1'b0;
    logic [IW-1:0] target_id_i = TGT;
    logic [NP-1:0] pb_act_cfg = '0;
    logic [NP-1:0] pb_intr_cfg = '0;
    logic [NP-1:0] pbdma_chan_active_i, pbdma_intr_i;
    logic intr_svc_ack_i = 1'b0;
    logic [2:0] st0 = 3'd0, st1 = 3'd0;
    logic [IW-1:0] cur0 = '0, cur1 = '0, nxt0 = '0, nxt1 = '0;
    logic [NE-1:0] eng_reinit_ack_i = '0;
    logic sched_disable_o, chan_disable_o, preempt_o, intr_svc_req_o;
    logic [NE-1:0] eng_halt_o, eng_reset_o, eng_reset_need_o;
    logic sched_enable_o, done_o;

    int case_id = 0;
    int svc_case = -1;
    logic svc_done;
    assign svc_done = (svc_case == case_id);
    assign pbdma_chan_active_i = svc_done ? '0 : pb_act_cfg;
    assign pbdma_intr_i        = svc_done ? '0 : pb_intr_cfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    gts_teardown_seq #(
        .NUM_PBDMA (NP), .NUM_ENG (NE), .ID_W (IW), .POLL_LIMIT (PL)
    ) u0 (
        .clk (clk), .rst (rst), .start_i (start_i), .imm_reset_i (imm_reset_i),
        .target_id_i (target_id_i),
        .pbdma_chan_active_i (pbdma_chan_active_i), .pbdma_intr_i (pbdma_intr_i),
        .intr_svc_ack_i (intr_svc_ack_i),
        .eng_ctx_stat_i ({st1, st0}), .eng_cur_id_i ({cur1, cur0}),
        .eng_next_id_i ({nxt1, nxt0}), .eng_reinit_ack_i (eng_reinit_ack_i),
        .sched_disable_o (sched_disable_o), .chan_disable_o (chan_disable_o),
        .preempt_o (preempt_o), .intr_svc_req_o (intr_svc_req_o),
        .eng_halt_o (eng_halt_o), .eng_reset_o (eng_reset_o),
        .eng_reset_need_o (eng_reset_need_o),
        .sched_enable_o (sched_enable_o), .done_o (done_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- scoreboard ----------------
    typedef enum int {EV_SDIS, EV_CDIS, EV_PRE, EV_INTR, EV_HALT, EV_RST, EV_SEN, EV_DONE} ev_kind_e;
    typedef struct {
        ev_kind_e      kind;
        logic [NE-1:0] mask;
        string         req;
    } ev_t;
    ev_t exp_q[$];

    task automatic push(input ev_kind_e k, input logic [NE-1:0] m, input string req);
        ev_t e;
        e.kind = k; e.mask = m; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic observe(input ev_kind_e k, input logic [NE-1:0] m);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(0, "R13", "unexpected strobe kind", k, 32'hFFFF);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == k && e.mask == m, e.req, "strobe kind/mask",
                  {k[15:0], 14'd0, m}, {e.kind[15:0], 14'd0, e.mask});
        end
    endtask

    logic p_sdis = 0, p_cdis = 0, p_pre = 0, p_intr = 0, p_sen = 0, p_done = 0;
    logic [NE-1:0] p_halt = '0, p_rst = '0;

    // monitor: sampled on the falling edge, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (sched_disable_o && !p_sdis) observe(EV_SDIS, '0);
            if (chan_disable_o && !p_cdis)  observe(EV_CDIS, '0);
            if (preempt_o && !p_pre)        observe(EV_PRE, '0);
            if (intr_svc_req_o && !p_intr)  observe(EV_INTR, '0);
            if (|eng_halt_o && !(|p_halt)) begin
                observe(EV_HALT, eng_halt_o);
                if (!imm_reset_i)
                    check(pbdma_chan_active_i == '0, "R4", "halt before drain", pbdma_chan_active_i, 0);
            end
            if (|eng_reset_o && !(|p_rst))  observe(EV_RST, eng_reset_o);
            if (sched_enable_o && !p_sen) begin
                observe(EV_SEN, '0);
                check(pbdma_chan_active_i == '0 || imm_reset_i, "R4", "enable before drain",
                      pbdma_chan_active_i, 0);
            end
            if (done_o && !p_done)          observe(EV_DONE, '0);
            if (done_o && p_done)           check(0, "R10", "done longer than one cycle", 2, 1);
        end
        p_sdis = sched_disable_o; p_cdis = chan_disable_o; p_pre = preempt_o;
        p_intr = intr_svc_req_o;  p_halt = eng_halt_o;     p_rst = eng_reset_o;
        p_sen  = sched_enable_o;  p_done = done_o;
    end

    // responder: interrupt service completes three cycles after the request
    int icnt = 0;
    always @(negedge clk) begin
        if (intr_svc_req_o && !intr_svc_ack_i) begin
            icnt = icnt + 1;
            if (icnt >= 3) begin
                intr_svc_ack_i = 1'b1;
                svc_case = case_id;
                icnt = 0;
            end
        end else begin
            intr_svc_ack_i = 1'b0;
        end
    end

    // responder: engine re-init acknowledge two cycles after its reset
    logic [NE-1:0] seen_rst = '0;
    int acnt [NE];
    initial for (int e = 0; e < NE; e++) acnt[e] = 0;
    always @(negedge clk) begin
        for (int e = 0; e < NE; e++) begin
            if (!eng_halt_o[e]) begin
                seen_rst[e] = 1'b0; acnt[e] = 0; eng_reinit_ack_i[e] = 1'b0;
            end else begin
                if (eng_reset_o[e]) seen_rst[e] = 1'b1;
                if (seen_rst[e]) begin
                    acnt[e] = acnt[e] + 1;
                    if (acnt[e] >= 2) eng_reinit_ack_i[e] = 1'b1;
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic run_case(input string req,
                            input logic [2:0] s0, input logic [2:0] s1,
                            input logic [IW-1:0] c0, input logic [IW-1:0] c1,
                            input logic [IW-1:0] n0, input logic [IW-1:0] n1,
                            input bit imm, input logic [NP-1:0] act, input logic [NP-1:0] irq,
                            input int release_after, input int poke_after,
                            input logic [NE-1:0] need);
        bit got_done;
        @(negedge clk);
        case_id = case_id + 1;
        st0 = s0; st1 = s1; cur0 = c0; cur1 = c1; nxt0 = n0; nxt1 = n1;
        imm_reset_i = imm; pb_act_cfg = act; pb_intr_cfg = irq;
        push(EV_SDIS, '0, "R1");
        push(EV_CDIS, '0, "R2");
        push(EV_PRE,  '0, "R3");
        if (!imm && irq != '0) push(EV_INTR, '0, "R4");
        if (need != '0) begin
            push(EV_HALT, need, "R9");
            push(EV_RST,  need, "R9");
        end
        push(EV_SEN,  '0, "R10");
        push(EV_DONE, '0, "R10");
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(sched_disable_o == 1'b1, "R1", "scheduling off one cycle after start", sched_disable_o, 1);
        got_done = 0;
        fork
            begin
                if (release_after > 0) begin
                    repeat (release_after) @(negedge clk);
                    st0 = 3'd0;
                end
            end
            begin
                if (poke_after > 0) begin
                    repeat (poke_after) @(negedge clk);
                    start_i = 1'b1;
                    @(negedge clk);
                    start_i = 1'b0;
                end
            end
            begin
                for (int i = 0; i < 400 && !got_done; i++) begin
                    @(negedge clk);
                    if (done_o) got_done = 1;
                end
            end
        join
        check(got_done, req, "done seen", got_done, 1);
        check(eng_reset_need_o == need, req, "reset-need mask", eng_reset_need_o, need);
        check(eng_reset_need_o == need, "R14", "mask held after done", eng_reset_need_o, need);
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, req, "strobes left unseen", exp_q.size(), 0);
        check(done_o == 1'b0, "R13", "no second done", done_o, 0);
        exp_q.delete();
        pb_act_cfg = '0; pb_intr_cfg = '0; imm_reset_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({sched_disable_o, chan_disable_o, preempt_o, intr_svc_req_o, eng_halt_o,
               eng_reset_o, sched_enable_o, done_o} == '0, "R1", "outputs low in reset",
              {sched_disable_o, chan_disable_o, preempt_o, intr_svc_req_o, eng_halt_o,
               eng_reset_o, sched_enable_o, done_o}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R6: both INVALID -> nothing reset
        run_case("R6", 3'd0, 3'd0, TGT, TGT, TGT, TGT, 0, '0, '0, 0, 0, 2'b00);
        // R7: VALID with matching current ID, SAVE with other ID
        run_case("R7", 3'd1, 3'd2, TGT, OTH, OTH, TGT, 0, '0, '0, 0, 0, 2'b01);
        // R8: LOAD judged by next ID only
        run_case("R8", 3'd3, 3'd3, OTH, TGT, TGT, OTH, 0, '0, '0, 0, 0, 2'b01);
        // R9: both engines reset together
        run_case("R9", 3'd2, 3'd1, TGT, TGT, OTH, OTH, 0, '0, '0, 0, 0, 2'b11);
        // R4: busy PBDMA with pending interrupt
        run_case("R4", 3'd0, 3'd0, OTH, OTH, OTH, OTH, 0, 2'b10, 2'b10, 0, 0, 2'b00);
        // R5: SWITCH that settles to INVALID before the limit
        run_case("R5", 3'd4, 3'd0, TGT, OTH, TGT, OTH, 0, '0, '0, 6, 0, 2'b00);
        // R11: SWITCH that never settles
        run_case("R11", 3'd0, 3'd4, OTH, TGT, OTH, TGT, 0, '0, '0, 0, 0, 2'b10);
        // R12: immediate mode bypasses drain and judging
        run_case("R12", 3'd0, 3'd0, OTH, OTH, OTH, OTH, 1, 2'b11, '0, 0, 0, 2'b11);
        // R13: extra start mid-run
        run_case("R13", 3'd1, 3'd2, TGT, OTH, OTH, TGT, 0, '0, '0, 0, 3, 2'b01);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule